// File: doc/BRIEF.md
# Serial Channel Mode and Command Register Unit

This block is the host-side control register logic for one asynchronous serial channel. Two mode registers share a single bus address. An internal pointer picks which one that address reaches. The pointer starts at the first mode register. It moves to the second one after any access to the first, and it stays there until a command sends it back.

A second, write-only address takes command bytes. Bits 6:4 of a command byte carry one encoded miscellaneous command. That command becomes a single-clock pulse to the receiver, transmitter, status or interrupt logic. Bits 3:2 and 1:0 of the same byte turn the transmitter and the receiver on or off. The unit holds those two enable levels. One write may combine a miscellaneous command with enable requests. When a unit is reset and enabled in the same write, the reset wins.

The bus is synchronous. A chip select qualifies the address and the read and write strobes, and data is 8 bits wide. The serial datapath is not part of this block.

Top module: `scc_ctrl_regs`

## Requirements
- R1: While reset is high and on the first cycle after it, the pointer selects mode register 1. Both mode registers, both enables and all four pulse outputs are 0.
- R2: A selected read or write of the mode address while the pointer is at mode register 1 moves the pointer to mode register 2 at that clock edge. A write stores the data in the register the pointer selected. A read returns, in the same cycle, the register the pointer selects.
- R3: While the pointer selects mode register 2, reads and writes of the mode address leave it there. Every such write overwrites mode register 2.
- R4: Command code 001 in bits 6:4 returns the pointer to mode register 1. Codes 000, 110 and 111 produce no pulse and leave the pointer alone. Bit 7 has no effect.
- R5: Code 010 gives a one-cycle receiver reset pulse in the cycle after the write and clears the receiver enable. Code 011 does the same for the transmitter.
- R6: Code 100 gives a one-cycle pulse that clears the break, parity, framing and overrun status bits (status bits 7:4). Code 101 gives a one-cycle pulse that clears the break-change interrupt flag (interrupt status bit 2).
- R7: Bits 3:2 set the transmitter enable and bits 1:0 set the receiver enable. In each field, 01 turns the unit on and 10 turns it off. Both 00 and 11 leave the level unchanged.
- R8: A reset command (code 010 or 011) in the same write as an enable request for that unit leaves the unit disabled. The other unit's request is still applied.
- R9: Each clock cycle with an active command write gives exactly one pulse per decoded command. At most one pulse output is high in any cycle.
- R10: Reads of the command address return 0. Bus activity with chip select low, or at any other address, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| addr | input | ADDR_W | Register address |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data (combinational) |
| mode1 | output | DATA_W | Mode register 1 contents |
| mode2 | output | DATA_W | Mode register 2 contents |
| ptr_sel | output | 1 | Pointer: 0 selects mode register 1, 1 selects mode register 2 |
| rx_en | output | 1 | Receiver enable level |
| tx_en | output | 1 | Transmitter enable level |
| rx_rst_pulse | output | 1 | One-cycle receiver reset |
| tx_rst_pulse | output | 1 | One-cycle transmitter reset |
| err_clr_pulse | output | 1 | One-cycle clear of status bits 7:4 |
| brk_clr_pulse | output | 1 | One-cycle clear of interrupt status bit 2 |

## Verification
The bench builds the unit with its defaults: 8-bit data, a 2-bit address, the mode registers at address 0 and the command register at address 2. Addresses 1 and 3 are left unused, so accesses to them can show that nothing else decodes as mode or command. With 8-bit data the whole command byte can be driven, including the unused bit 7 and the reserved codes. Conflicting reset and enable combinations can be applied to each unit.

// File: rtl/scc_pkg.sv
package scc_pkg;

    typedef enum logic [2:0] {
        MC_NONE    = 3'd0,
        MC_PTR_RST = 3'd1,
        MC_RX_RST  = 3'd2,
        MC_TX_RST  = 3'd3,
        MC_ERR_CLR = 3'd4,
        MC_BRK_CLR = 3'd5,
        MC_RSV6    = 3'd6,
        MC_RSV7    = 3'd7
    } misc_cmd_e;

    typedef enum logic [1:0] {
        EN_KEEP = 2'd0,
        EN_ON   = 2'd1,
        EN_OFF  = 2'd2,
        EN_BAD  = 2'd3
    } en_req_e;

    typedef struct packed {
        logic      spare;
        misc_cmd_e misc;
        en_req_e   tx_req;
        en_req_e   rx_req;
    } cmd_word_t;

    localparam int CMD_W = $bits(cmd_word_t);

    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic err_clr;
        logic brk_clr;
    } cmd_pulse_t;

    function automatic cmd_pulse_t decode_misc(misc_cmd_e m);
        cmd_pulse_t p;
        p = '0;
        case (m)
            MC_PTR_RST: p.ptr_rst = 1'b1;
            MC_RX_RST:  p.rx_rst  = 1'b1;
            MC_TX_RST:  p.tx_rst  = 1'b1;
            MC_ERR_CLR: p.err_clr = 1'b1;
            MC_BRK_CLR: p.brk_clr = 1'b1;
            default:    p = '0;
        endcase
        return p;
    endfunction

    // Unit reset dominates any enable request in the same write.
    function automatic logic next_enable(logic cur, logic unit_rst, en_req_e req);
        if (unit_rst)
            return 1'b0;
        case (req)
            EN_ON:   return 1'b1;
            EN_OFF:  return 1'b0;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/scc_mode_bank.sv
module scc_mode_bank #(
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  MR1_RST = 8'h00,
    parameter logic [7:0]  MR2_RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ptr_clr,
    output logic [DATA_W-1:0] mode1,
    output logic [DATA_W-1:0] mode2,
    output logic              ptr_sel,
    output logic [DATA_W-1:0] rd_val
);
    localparam int NREG = 2;

    logic [DATA_W-1:0] regs_q [NREG];
    logic              ptr_q;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DATA_W-1:0] RST_V =
            (g == 0) ? DATA_W'(MR1_RST) : DATA_W'(MR2_RST);
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= RST_V;
            else if (acc && wr_en && (int'(ptr_q) == g))
                regs_q[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= 1'b0;
        else if (ptr_clr)
            ptr_q <= 1'b0;
        else if (acc)
            ptr_q <= 1'b1;
    end

    assign mode1   = regs_q[0];
    assign mode2   = regs_q[1];
    assign ptr_sel = ptr_q;
    assign rd_val  = regs_q[ptr_q];
endmodule

// File: rtl/scc_cmd_decode.sv
module scc_cmd_decode
    import scc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  cmd_word_t  cmd,
    output cmd_pulse_t now,
    output cmd_pulse_t pulse_q
);
    always_comb begin
        now = cmd_wr ? decode_misc(cmd.misc) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pulse_q <= '0;
        else
            pulse_q <= now;
    end
endmodule

// File: rtl/scc_enable_ctl.sv
module scc_enable_ctl
    import scc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  cmd_word_t  cmd,
    input  cmd_pulse_t now,
    output logic       rx_en,
    output logic       tx_en
);
    localparam int NUNIT = 2;

    logic    en_q      [NUNIT];
    en_req_e req_v     [NUNIT];
    logic    unit_rst  [NUNIT];

    assign req_v[0]    = cmd.rx_req;
    assign req_v[1]    = cmd.tx_req;
    assign unit_rst[0] = now.rx_rst;
    assign unit_rst[1] = now.tx_rst;

    for (genvar g = 0; g < NUNIT; g++) begin : g_unit
        always_ff @(posedge clk) begin
            if (rst)
                en_q[g] <= 1'b0;
            else if (cmd_wr)
                en_q[g] <= next_enable(en_q[g], unit_rst[g], req_v[g]);
        end
    end

    assign rx_en = en_q[0];
    assign tx_en = en_q[1];
endmodule

// File: rtl/scc_ctrl_regs.sv
module scc_ctrl_regs
    import scc_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 2,
    parameter int MODE_ADDR = 0,
    parameter int CMD_ADDR  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] mode1,
    output logic [DATA_W-1:0] mode2,
    output logic              ptr_sel,
    output logic              rx_en,
    output logic              tx_en,
    output logic              rx_rst_pulse,
    output logic              tx_rst_pulse,
    output logic              err_clr_pulse,
    output logic              brk_clr_pulse
);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_ADDR);

    logic              hit_mode;
    logic              hit_cmd;
    logic              mode_acc;
    logic              cmd_wr;
    cmd_word_t         cmd;
    cmd_pulse_t        now;
    cmd_pulse_t        pulse_q;
    logic [DATA_W-1:0] mode_rd;

    assign hit_mode = cs && (addr == MODE_A);
    assign hit_cmd  = cs && (addr == CMD_A);
    assign mode_acc = hit_mode && (rd || wr);
    assign cmd_wr   = hit_cmd && wr;
    assign cmd      = cmd_word_t'(wdata[CMD_W-1:0]);

    scc_cmd_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .cmd_wr  (cmd_wr),
        .cmd     (cmd),
        .now     (now),
        .pulse_q (pulse_q)
    );

    scc_mode_bank #(.DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .acc     (mode_acc),
        .wr_en   (wr),
        .wdata   (wdata),
        .ptr_clr (now.ptr_rst),
        .mode1   (mode1),
        .mode2   (mode2),
        .ptr_sel (ptr_sel),
        .rd_val  (mode_rd)
    );

    scc_enable_ctl u_en (
        .clk    (clk),
        .rst    (rst),
        .cmd_wr (cmd_wr),
        .cmd    (cmd),
        .now    (now),
        .rx_en  (rx_en),
        .tx_en  (tx_en)
    );

    always_comb begin
        rdata = '0;
        if (hit_mode && rd)
            rdata = mode_rd;
    end

    assign rx_rst_pulse  = pulse_q.rx_rst;
    assign tx_rst_pulse  = pulse_q.tx_rst;
    assign err_clr_pulse = pulse_q.err_clr;
    assign brk_clr_pulse = pulse_q.brk_clr;
endmodule

// File: rtl/scc_ctrl_regs_chk.sv
module scc_ctrl_regs_chk #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 2,
    parameter int MODE_ADDR = 0,
    parameter int CMD_ADDR  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cs,
    input logic [ADDR_W-1:0] addr,
    input logic              wr,
    input logic              rd,
    input logic [DATA_W-1:0] wdata,
    input logic              ptr_sel,
    input logic              rx_en,
    input logic              tx_en,
    input logic              rx_rst_pulse,
    input logic              tx_rst_pulse,
    input logic              err_clr_pulse,
    input logic              brk_clr_pulse
);
    logic m_acc, c_wr;
    assign m_acc = cs && (int'(addr) == MODE_ADDR) && (rd || wr);
    assign c_wr  = cs && wr && (int'(addr) == CMD_ADDR);

    p_reset_ptr_r1: assert property (@(posedge clk) rst |=> !ptr_sel && !rx_en && !tx_en);

    p_ptr_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (m_acc && !ptr_sel) |=> ptr_sel);

    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ptr_sel && !(c_wr && wdata[6:4] == 3'd1)) |=> ptr_sel);

    p_ptr_return_r4: assert property (@(posedge clk) disable iff (rst)
        (c_wr && wdata[6:4] == 3'd1) |=> !ptr_sel);

    p_rx_reset_r5: assert property (@(posedge clk) disable iff (rst)
        (c_wr && wdata[6:4] == 3'd2) |=> rx_rst_pulse && !rx_en);

    p_tx_reset_r5: assert property (@(posedge clk) disable iff (rst)
        (c_wr && wdata[6:4] == 3'd3) |=> tx_rst_pulse && !tx_en);

    p_err_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (c_wr && wdata[6:4] == 3'd4) |=> err_clr_pulse);

    p_brk_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (c_wr && wdata[6:4] == 3'd5) |=> brk_clr_pulse);

    p_tx_on_r7: assert property (@(posedge clk) disable iff (rst)
        (c_wr && wdata[3:2] == 2'b01 && wdata[6:4] != 3'd3) |=> tx_en);

    p_rx_off_r7: assert property (@(posedge clk) disable iff (rst)
        (c_wr && wdata[1:0] == 2'b10) |=> !rx_en);

    p_one_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_rst_pulse, tx_rst_pulse, err_clr_pulse, brk_clr_pulse}));

    p_no_cmd_no_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        !c_wr |=> !(rx_rst_pulse || tx_rst_pulse || err_clr_pulse || brk_clr_pulse));

    p_idle_enables_r10: assert property (@(posedge clk) disable iff (rst)
        !c_wr |=> $stable(rx_en) && $stable(tx_en));
endmodule

bind scc_ctrl_regs scc_ctrl_regs_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .CMD_ADDR(CMD_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .cs(cs), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
    .ptr_sel(ptr_sel), .rx_en(rx_en), .tx_en(tx_en),
    .rx_rst_pulse(rx_rst_pulse), .tx_rst_pulse(tx_rst_pulse),
    .err_clr_pulse(err_clr_pulse), .brk_clr_pulse(brk_clr_pulse)
);

// File: tb/scc_ctrl_regs_test.sv
module scc_ctrl_regs_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0;
    logic [1:0] addr = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, mode1, mode2;
    logic       ptr_sel, rx_en, tx_en;
    logic       rx_rst_pulse, tx_rst_pulse, err_clr_pulse, brk_clr_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // behavioural reference state
    int m_ptr, m_mr1, m_mr2, m_rx, m_tx, m_prx, m_ptx, m_perr, m_pbrk;

    always #10 clk = ~clk;

    scc_ctrl_regs uut (
        .clk(clk), .rst(rst), .cs(cs), .addr(addr), .wr(wr), .rd(rd),
        .wdata(wdata), .rdata(rdata), .mode1(mode1), .mode2(mode2),
        .ptr_sel(ptr_sel), .rx_en(rx_en), .tx_en(tx_en),
        .rx_rst_pulse(rx_rst_pulse), .tx_rst_pulse(tx_rst_pulse),
        .err_clr_pulse(err_clr_pulse), .brk_clr_pulse(brk_clr_pulse)
    );

    task automatic cmp(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        int code;
        m_prx = 0; m_ptx = 0; m_perr = 0; m_pbrk = 0;
        if (rst) begin
            m_ptr = 0; m_mr1 = 0; m_mr2 = 0; m_rx = 0; m_tx = 0;
            return;
        end
        if (cs && wr && addr == 2) begin
            code = int'(wdata[6:4]);
            if (code == 1) m_ptr = 0;
            if (code == 2) m_prx = 1;
            if (code == 3) m_ptx = 1;
            if (code == 4) m_perr = 1;
            if (code == 5) m_pbrk = 1;
            if (wdata[3:2] == 2'b01) m_tx = 1;
            if (wdata[3:2] == 2'b10) m_tx = 0;
            if (wdata[1:0] == 2'b01) m_rx = 1;
            if (wdata[1:0] == 2'b10) m_rx = 0;
            if (m_prx) m_rx = 0;
            if (m_ptx) m_tx = 0;
        end
        if (cs && (rd || wr) && addr == 0) begin
            if (wr) begin
                if (m_ptr == 0) m_mr1 = int'(wdata);
                else            m_mr2 = int'(wdata);
            end
            m_ptr = 1;
        end
    endtask

    task automatic step(string tag, bit r, bit c, int a, bit w, bit rr, int d);
        int exp_rd;
        rst = r; cs = c; addr = 2'(a); wr = w; rd = rr; wdata = 8'(d);
        #2;
        exp_rd = (c && rr && a == 0 && !r) ? ((m_ptr != 0) ? m_mr2 : m_mr1) : 0;
        if (!r) cmp(tag, "rdata", int'(rdata), exp_rd);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cmp(tag, "ptr_sel", int'(ptr_sel), m_ptr);
        cmp(tag, "mode1", int'(mode1), m_mr1);
        cmp(tag, "mode2", int'(mode2), m_mr2);
        cmp(tag, "rx_en", int'(rx_en), m_rx);
        cmp(tag, "tx_en", int'(tx_en), m_tx);
        cmp(tag, "rx_rst_pulse", int'(rx_rst_pulse), m_prx);
        cmp(tag, "tx_rst_pulse", int'(tx_rst_pulse), m_ptx);
        cmp(tag, "err_clr_pulse", int'(err_clr_pulse), m_perr);
        cmp(tag, "brk_clr_pulse", int'(brk_clr_pulse), m_pbrk);
    endtask

    task automatic idle(string tag);
        step(tag, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0);
    endtask

    task automatic cmdw(string tag, int d);
        step(tag, 1'b0, 1'b1, 2, 1'b1, 1'b0, d);
        idle(tag);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        step("R1", 1'b1, 1'b0, 0, 1'b0, 1'b0, 0);
        step("R1", 1'b1, 1'b1, 0, 1'b1, 1'b0, 8'h77);
        idle("R1");
        // R2: first access goes to mode 1 and advances the pointer
        step("R2", 1'b0, 1'b1, 0, 1'b1, 1'b0, 8'hA5);
        // R3: further accesses stay on mode 2
        step("R3", 1'b0, 1'b1, 0, 1'b1, 1'b0, 8'h3C);
        step("R3", 1'b0, 1'b1, 0, 1'b1, 1'b0, 8'h5A);
        step("R3", 1'b0, 1'b1, 0, 1'b0, 1'b1, 0);
        // R4: pointer return, then a read of mode 1 advances it
        cmdw("R4", 8'h10);
        step("R2", 1'b0, 1'b1, 0, 1'b0, 1'b1, 0);
        step("R3", 1'b0, 1'b1, 0, 1'b0, 1'b1, 0);
        // R10: chip select low, other addresses, command reads
        step("R10", 1'b0, 1'b0, 0, 1'b1, 1'b0, 8'hFF);
        step("R10", 1'b0, 1'b1, 1, 1'b1, 1'b1, 8'h15);
        step("R10", 1'b0, 1'b1, 3, 1'b1, 1'b0, 8'h25);
        step("R10", 1'b0, 1'b1, 2, 1'b0, 1'b1, 0);
        step("R10", 1'b0, 1'b0, 2, 1'b1, 1'b0, 8'h15);
        // R4: pointer return with bit 7 set, then a write lands in mode 1
        cmdw("R4", 8'h90);
        step("R2", 1'b0, 1'b1, 0, 1'b1, 1'b0, 8'hC3);
        // R7: enable fields
        cmdw("R7", 8'h05);
        cmdw("R7", 8'h0F);
        cmdw("R7", 8'h00);
        cmdw("R7", 8'h08);
        cmdw("R7", 8'h02);
        cmdw("R7", 8'h01);
        cmdw("R7", 8'h04);
        // R4: no-op and reserved codes
        cmdw("R4", 8'h00);
        cmdw("R4", 8'h60);
        cmdw("R4", 8'h70);
        // R5: unit resets
        cmdw("R5", 8'h20);
        cmdw("R5", 8'h05);
        cmdw("R5", 8'h30);
        // R6: status and interrupt clears
        cmdw("R6", 8'h40);
        cmdw("R6", 8'hC0);
        cmdw("R6", 8'h50);
        // R8: reset versus enable in one write
        cmdw("R8", 8'h05);
        cmdw("R8", 8'h21);
        cmdw("R8", 8'h34);
        cmdw("R8", 8'h25);
        cmdw("R8", 8'h3A);
        // R9: command strobe held for several cycles
        step("R9", 1'b0, 1'b1, 2, 1'b1, 1'b0, 8'h40);
        step("R9", 1'b0, 1'b1, 2, 1'b1, 1'b0, 8'h50);
        step("R9", 1'b0, 1'b1, 2, 1'b1, 1'b0, 8'h20);
        idle("R9");
        idle("R9");
        // R1: reset mid-run clears everything
        cmdw("R1", 8'h05);
        step("R1", 1'b0, 1'b1, 0, 1'b1, 1'b0, 8'h11);
        step("R1", 1'b1, 1'b0, 0, 1'b0, 1'b0, 0);
        idle("R1");
        step("R2", 1'b0, 1'b1, 0, 1'b0, 1'b1, 0);
        idle("R2");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule